// File: doc/BRIEF.md
# Core Low-Power State Sequencer

This block decides when a processor core leaves full speed, which low-power state it drops into, and how it comes back. Software first writes the mode-select bits (doze, nap, sleep) and later raises a separate power-request bit. Only the combination of the two moves the core out of full power. Until a wake event arrives, the core is held halted, every unit clock enable is off, and a flag tells the clock generator whether its PLL must stay locked.

A wake event is a machine check or a soft reset, which always wake the core. An external interrupt, a system management interrupt or a decrementer interrupt also wakes it, but only while the external-interrupt enable is set. A wake starts a fixed exit window, clears the power request and then signals ready. The block reset acts as the hard reset and returns the core to full power at once.

At full speed, an optional dynamic mode turns off the clock enable of any unit that reports itself idle. Busy units keep running unchanged.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: While `rst_n` is low and in the cycle after it rises, the outputs are: `mode`=00, `ready`=1, `core_halt`=0, `pll_keep`=1, `pow_req`=0, and every `unit_clk_en` bit is 1 when `dpm_en`=0.
- R2: At full power with `dpm_en`=1, `unit_clk_en` equals `unit_busy` bit for bit. With `dpm_en`=0, every bit of `unit_clk_en` is 1.
- R3: A one-cycle `pow_set` pulse sets `pow_req` at the next edge. With `pow_req`=1 and at least one select bit set at full power, the next edge enters the selected state. `mode` then reads 01 for doze, 10 for nap and 11 for sleep.
- R4: When several select bits are set, sleep wins over nap, and nap wins over doze.
- R5: With `pow_req`=1 and no select bit set, the core stays at full power and `core_halt` stays 0.
- R6: In any low-power state, `core_halt`=1, `ready`=0 and `unit_clk_en` is all zero. `pll_keep` is 1 in doze and nap and 0 in sleep.
- R7: `mchk` and `soft_rst` wake the core regardless of `ext_irq_en`. `ext_irq`, `smi` and `dec_irq` wake it only while `ext_irq_en`=1.
- R8: A masked interrupt (`ext_irq`, `smi` or `dec_irq` with `ext_irq_en`=0) leaves the core halted in its state.
- R9: After the edge that samples a wake, the block spends EXIT_CYC (default 4) cycles in the exit window. During that window `mode`=00, `core_halt`=0, `ready`=0 and `unit_clk_en` is all ones. `ready` returns to 1 at the EXIT_CYC-th edge after the wake edge.
- R10: A wake clears `pow_req` on the wake edge, and the core does not re-enter a low-power state afterwards while the select bits stay set.
- R11: Driving `rst_n` low while in a low-power state returns the core to full power with `ready`=1 on the next sampled cycle.
- R12: Changing the select bits while in a low-power state leaves `mode` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Active-low hard reset |
| dpm_en | input | 1 | Dynamic gating of idle units at full power |
| sel_doze | input | 1 | Doze select bit |
| sel_nap | input | 1 | Nap select bit |
| sel_sleep | input | 1 | Sleep select bit |
| pow_set | input | 1 | Pulse that sets the power-request bit |
| ext_irq_en | input | 1 | External-interrupt enable |
| ext_irq | input | 1 | External interrupt |
| smi | input | 1 | System management interrupt |
| mchk | input | 1 | Machine check |
| dec_irq | input | 1 | Decrementer interrupt |
| soft_rst | input | 1 | Soft reset |
| unit_busy | input | N_UNITS | Per-unit busy indication |
| unit_clk_en | output | N_UNITS | Per-unit clock enable |
| core_halt | output | 1 | Core is in a low-power state |
| pll_keep | output | 1 | PLL must remain running and locked |
| mode | output | 2 | Current low-power state: 00 full/exit, 01 doze, 10 nap, 11 sleep |
| ready | output | 1 | Core is at full power |
| pow_req | output | 1 | Power-request bit |

## Verification
The bound checker watches, on every cycle, the rules that hold within a cycle or across one edge. These are the output values while halted, the PLL flag in sleep, entry on request, no entry without a select, the state that the select priority picks, the clearing of the request on wake, and that masked sources keep the core halted. The exact length of the exit window, the unmasked wake from each source in each state, hard reset from a low-power state, and the stability of the state under select changes are shown only by the bench's scenarios, which walk every state against every wake source.

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl #(
  parameter int N_UNITS  = 5,
  parameter int EXIT_CYC = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               dpm_en,
  input  logic               sel_doze,
  input  logic               sel_nap,
  input  logic               sel_sleep,
  input  logic               pow_set,
  input  logic               ext_irq_en,
  input  logic               ext_irq,
  input  logic               smi,
  input  logic               mchk,
  input  logic               dec_irq,
  input  logic               soft_rst,
  input  logic [N_UNITS-1:0] unit_busy,
  output logic [N_UNITS-1:0] unit_clk_en,
  output logic               core_halt,
  output logic               pll_keep,
  output logic [1:0]         mode,
  output logic               ready,
  output logic               pow_req
);

  localparam int CW = $clog2(EXIT_CYC + 1);

  typedef enum logic [2:0] {
    ST_FULL  = 3'd0,
    ST_DOZE  = 3'd1,
    ST_NAP   = 3'd2,
    ST_SLEEP = 3'd3,
    ST_EXIT  = 3'd4
  } st_t;

  st_t         st;
  st_t         tgt;
  logic [CW-1:0] cnt;
  logic        req_q;
  logic        low;
  logic        any_sel;
  logic        wake;

  assign any_sel = sel_doze | sel_nap | sel_sleep;
  assign wake    = mchk | soft_rst | (ext_irq_en & (ext_irq | smi | dec_irq));
  assign low     = (st == ST_DOZE) || (st == ST_NAP) || (st == ST_SLEEP);
  assign tgt     = sel_sleep ? ST_SLEEP : (sel_nap ? ST_NAP : ST_DOZE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= ST_FULL;
      cnt   <= '0;
      req_q <= 1'b0;
    end else begin
      case (st)
        ST_FULL: begin
          if (pow_set) req_q <= 1'b1;
          if (req_q && any_sel) st <= tgt;
        end
        ST_DOZE, ST_NAP, ST_SLEEP: begin
          if (wake) begin
            st    <= ST_EXIT;
            cnt   <= CW'(EXIT_CYC - 1);
            req_q <= 1'b0;
          end
        end
        ST_EXIT: begin
          if (cnt == '0) st <= ST_FULL;
          else           cnt <= cnt - 1'b1;
        end
        default: st <= ST_FULL;
      endcase
    end
  end

  assign core_halt   = low;
  assign ready       = (st == ST_FULL);
  assign pll_keep    = (st != ST_SLEEP);
  assign mode        = low ? st[1:0] : 2'b00;
  assign pow_req     = req_q;
  assign unit_clk_en = low ? '0 : ((st == ST_FULL && dpm_en) ? unit_busy : '1);

endmodule

// File: rtl/pwr_mode_ctrl_chk.sv
module pwr_mode_ctrl_chk #(
  parameter int N_UNITS = 5
) (
  input logic               clk,
  input logic               rst_n,
  input logic               dpm_en,
  input logic               sel_doze,
  input logic               sel_nap,
  input logic               sel_sleep,
  input logic               pow_set,
  input logic               ext_irq_en,
  input logic               ext_irq,
  input logic               smi,
  input logic               mchk,
  input logic               dec_irq,
  input logic               soft_rst,
  input logic [N_UNITS-1:0] unit_busy,
  input logic [N_UNITS-1:0] unit_clk_en,
  input logic               core_halt,
  input logic               pll_keep,
  input logic [1:0]         mode,
  input logic               ready,
  input logic               pow_req
);

  AST_DPM_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    ready && dpm_en |-> unit_clk_en == unit_busy); // R2

  AST_ENTER_ON_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    ready && pow_req && (sel_doze || sel_nap || sel_sleep) |=> core_halt); // R3

  AST_SLEEP_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(core_halt) && $past(sel_sleep) |-> mode == 2'b11); // R4

  AST_NAP_OVER_DOZE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(core_halt) && !$past(sel_sleep) && $past(sel_nap) |-> mode == 2'b10); // R4

  AST_NO_SEL_STAY: assert property (@(posedge clk) disable iff (!rst_n)
    ready && !(sel_doze || sel_nap || sel_sleep) |=> !core_halt); // R5

  AST_HALT_OUTPUTS: assert property (@(posedge clk) disable iff (!rst_n)
    core_halt |-> unit_clk_en == '0 && !ready && mode != 2'b00); // R6

  AST_SLEEP_PLL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    core_halt |-> pll_keep == (mode != 2'b11)); // R6

  AST_MASKED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    core_halt && !mchk && !soft_rst && !ext_irq_en |=> core_halt); // R8

  AST_WAKE_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(core_halt) |-> !ready && mode == 2'b00); // R9

  AST_WAKE_CLEARS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(core_halt) |-> !pow_req); // R10

endmodule

bind pwr_mode_ctrl pwr_mode_ctrl_chk #(.N_UNITS(N_UNITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .dpm_en(dpm_en), .sel_doze(sel_doze),
  .sel_nap(sel_nap), .sel_sleep(sel_sleep), .pow_set(pow_set),
  .ext_irq_en(ext_irq_en), .ext_irq(ext_irq), .smi(smi), .mchk(mchk),
  .dec_irq(dec_irq), .soft_rst(soft_rst), .unit_busy(unit_busy),
  .unit_clk_en(unit_clk_en), .core_halt(core_halt), .pll_keep(pll_keep),
  .mode(mode), .ready(ready), .pow_req(pow_req)
);

// File: tb/tb_pwr_mode_ctrl.sv
module tb_pwr_mode_ctrl;
  localparam int NU = 5;
  localparam int XC = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dpm_en = 1'b0, sel_doze = 1'b0, sel_nap = 1'b0, sel_sleep = 1'b0;
  logic pow_set = 1'b0, ext_irq_en = 1'b0, ext_irq = 1'b0, smi = 1'b0;
  logic mchk = 1'b0, dec_irq = 1'b0, soft_rst = 1'b0;
  logic [NU-1:0] unit_busy = '0;
  logic [NU-1:0] unit_clk_en;
  logic core_halt, pll_keep, ready, pow_req;
  logic [1:0] mode;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pwr_mode_ctrl #(.N_UNITS(NU), .EXIT_CYC(XC)) dut (
    .clk(clk), .rst_n(rst_n), .dpm_en(dpm_en), .sel_doze(sel_doze),
    .sel_nap(sel_nap), .sel_sleep(sel_sleep), .pow_set(pow_set),
    .ext_irq_en(ext_irq_en), .ext_irq(ext_irq), .smi(smi), .mchk(mchk),
    .dec_irq(dec_irq), .soft_rst(soft_rst), .unit_busy(unit_busy),
    .unit_clk_en(unit_clk_en), .core_halt(core_halt), .pll_keep(pll_keep),
    .mode(mode), .ready(ready), .pow_req(pow_req)
  );

  // {sel_sleep,sel_nap,sel_doze}, ext_irq_en, source, expect wake, expect mode
  // source: 0 mchk, 1 soft_rst, 2 ext_irq, 3 smi, 4 dec_irq
  localparam logic [9:0] VEC [21] = '{
    {3'b001, 1'b1, 3'd0, 1'b1, 2'b01}, {3'b001, 1'b1, 3'd1, 1'b1, 2'b01},
    {3'b001, 1'b1, 3'd2, 1'b1, 2'b01}, {3'b001, 1'b1, 3'd3, 1'b1, 2'b01},
    {3'b001, 1'b1, 3'd4, 1'b1, 2'b01},
    {3'b010, 1'b1, 3'd0, 1'b1, 2'b10}, {3'b010, 1'b1, 3'd1, 1'b1, 2'b10},
    {3'b010, 1'b1, 3'd2, 1'b1, 2'b10}, {3'b010, 1'b1, 3'd3, 1'b1, 2'b10},
    {3'b010, 1'b1, 3'd4, 1'b1, 2'b10},
    {3'b100, 1'b1, 3'd0, 1'b1, 2'b11}, {3'b100, 1'b1, 3'd1, 1'b1, 2'b11},
    {3'b100, 1'b1, 3'd2, 1'b1, 2'b11}, {3'b100, 1'b1, 3'd3, 1'b1, 2'b11},
    {3'b100, 1'b1, 3'd4, 1'b1, 2'b11},
    {3'b001, 1'b0, 3'd2, 1'b0, 2'b01}, {3'b010, 1'b0, 3'd3, 1'b0, 2'b10},
    {3'b100, 1'b0, 3'd4, 1'b0, 2'b11},
    {3'b111, 1'b0, 3'd0, 1'b1, 2'b11}, {3'b011, 1'b0, 3'd1, 1'b1, 2'b10},
    {3'b101, 1'b1, 3'd2, 1'b1, 2'b11}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic set_src(input int s, input logic v);
    case (s)
      0: mchk = v;
      1: soft_rst = v;
      2: ext_irq = v;
      3: smi = v;
      default: dec_irq = v;
    endcase
  endtask

  task automatic request();
    pow_set = 1'b1;
    step();
    pow_set = 1'b0;
    step();
  endtask

  task automatic exit_window(input string req);
    int rdy_seen = 0;
    for (int i = 0; i < XC - 1; i++) begin
      step();
      if (ready) rdy_seen++;
    end
    chk(rdy_seen == 0, req, rdy_seen, 0);
    step();
    chk(ready == 1'b1, req, ready, 1);
  endtask

  task automatic run_vec(input logic [9:0] v);
    {sel_sleep, sel_nap, sel_doze} = v[9:7];
    ext_irq_en = v[6];
    request();
    chk(core_halt && mode == v[1:0], "R3/R4 entry mode", mode, v[1:0]);
    chk(pll_keep == (v[1:0] != 2'b11) && unit_clk_en == '0 && !ready,
        "R6 halted outputs", {pll_keep, unit_clk_en}, {(v[1:0] != 2'b11), 5'b0});
    set_src(int'(v[5:3]), 1'b1);
    step();
    set_src(int'(v[5:3]), 1'b0);
    if (v[2]) begin
      chk(!core_halt && !ready && mode == 2'b00 && unit_clk_en == '1,
          "R7 wake / R9 exit window", {core_halt, ready, mode}, 4'b0000);
      chk(pow_req == 1'b0, "R10 request cleared", pow_req, 0);
      exit_window("R9 exit delay");
      step(); step();
      chk(!core_halt && ready, "R10 no re-entry", core_halt, 0);
    end else begin
      step(); step();
      chk(core_halt && mode == v[1:0], "R8 masked source", mode, v[1:0]);
      mchk = 1'b1;
      step();
      mchk = 1'b0;
      exit_window("R7 mchk after masked");
    end
    {sel_sleep, sel_nap, sel_doze} = 3'b000;
    step();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    chk(ready && !core_halt && mode == 2'b00 && pll_keep && !pow_req && unit_clk_en == '1,
        "R1 in reset", {ready, core_halt, pow_req}, 3'b100);
    step();
    rst_n = 1'b1;
    step();
    chk(ready && !core_halt && !pow_req && unit_clk_en == '1, "R1 after reset",
        unit_clk_en, 5'h1f);

    dpm_en = 1'b1;
    unit_busy = 5'b10110;
    step();
    chk(unit_clk_en == 5'b10110, "R2 gating busy", unit_clk_en, 5'b10110);
    unit_busy = 5'b00001;
    step();
    chk(unit_clk_en == 5'b00001, "R2 gating one", unit_clk_en, 5'b00001);
    dpm_en = 1'b0;
    step();
    chk(unit_clk_en == 5'h1f, "R2 disabled", unit_clk_en, 5'h1f);

    request();
    chk(pow_req == 1'b1 && !core_halt && ready, "R5 no select stays full", core_halt, 0);
    step(); step();
    chk(!core_halt, "R5 still full", core_halt, 0);
    sel_doze = 1'b1;
    step();
    chk(core_halt && mode == 2'b01, "R3 late select enters", mode, 1);
    mchk = 1'b1;
    step();
    mchk = 1'b0;
    sel_doze = 1'b0;
    exit_window("R9 after late select");

    for (int i = 0; i < 21; i++) run_vec(VEC[i]);

    sel_nap = 1'b1;
    request();
    chk(mode == 2'b10, "R12 nap entered", mode, 2);
    sel_nap = 1'b0;
    sel_sleep = 1'b1;
    step(); step();
    chk(mode == 2'b10 && core_halt, "R12 select change ignored", mode, 2);
    chk(pll_keep == 1'b1, "R12 pll kept in nap", pll_keep, 1);
    sel_nap = 1'b0;
    soft_rst = 1'b1;
    step();
    soft_rst = 1'b0;
    sel_sleep = 1'b0;
    exit_window("R9 after select change");

    sel_sleep = 1'b1;
    request();
    chk(mode == 2'b11 && !pll_keep, "R11 sleep entered", mode, 3);
    rst_n = 1'b0;
    #1;
    chk(ready && !core_halt && pll_keep, "R11 hard reset wakes", ready, 1);
    sel_sleep = 1'b0;
    step();
    rst_n = 1'b1;
    step();
    chk(ready && !pow_req, "R11 stays full after reset", pow_req, 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule